// File: doc/BRIEF.md
# Difference or Zero Unit

This block is a 32-bit signed integer unit. It returns the difference `op_b - op_a` when `op_b` is strictly greater than `op_a`, and zero in every other case. Both operands are read as two's-complement numbers. The difference is kept to 32 bits. If a difference that should be positive wraps to a negative word, the unit flags an overflow. This is the only overflow condition it recognises; the usual add/subtract overflow rule does not apply.

The caller also passes in the current summary-overflow and overflow bits of the fixed-point status register. The unit returns their updated values. When the record flag is set, it also produces a 4-bit condition field. The status bits are settled before the condition field is formed, because the field's last bit copies the updated summary-overflow bit. All outputs are registered and become valid one cycle after `in_valid`. When no operation is presented, the outputs keep their values.

Top module: `dz_unit`

## Requirements
- R1: The result, the status bits and the condition outputs become valid on `out_valid` exactly one clock after `in_valid`. Reset clears every output to zero. While `in_valid` is low, all data outputs hold their previous values.
- R2: When signed `op_b` > signed `op_a`, `result` equals `op_b - op_a` modulo 2^32.
- R3: When signed `op_a` >= signed `op_b`, `result` is zero.
- R4: With `ov_en` set, `xer_ov_out` is 1 exactly when the subtraction was performed and bit 31 of its result is 1. In every other case `xer_ov_out` is cleared to 0.
- R5: With `ov_en` clear, `xer_ov_out` equals `xer_ov_in`.
- R6: `xer_so_out` equals `xer_so_in` OR the overflow detected under `ov_en`. The unit never clears a set summary bit.
- R7: With `rec_en` set, `cr_wr` is 1 and `cr_field` is {LT, GT, EQ, SO} in bits 3 down to 0:
  - LT = bit 31 of `result`;
  - GT = `result` is nonzero and bit 31 is 0;
  - EQ = `result` is zero;
  - SO = the updated `xer_so_out`.
- R8: With `rec_en` clear, `cr_wr` is 0 and `cr_field` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_a | input | WIDTH | Subtrahend, signed |
| op_b | input | WIDTH | Minuend, signed |
| ov_en | input | 1 | Overflow update enable |
| rec_en | input | 1 | Condition record enable |
| xer_so_in | input | 1 | Current summary-overflow bit |
| xer_ov_in | input | 1 | Current overflow bit |
| out_valid | output | 1 | Registered outputs carry a new result |
| result | output | WIDTH | Difference or zero |
| xer_ov_out | output | 1 | Updated overflow bit |
| xer_so_out | output | 1 | Updated summary-overflow bit |
| cr_wr | output | 1 | Condition field should be written |
| cr_field | output | 4 | {LT, GT, EQ, SO} |

## Verification
The assertions compare registered outputs against `$past` of the inputs. They therefore assume that the operands and flags carry known values in every cycle where `in_valid` is high. The bench drives every input at the falling edge and never leaves one undriven. It holds reset for two cycles before the first operation. Overflow cases are reached by pairing operands of opposite sign at the ends of the signed range, not by random search alone.

// File: rtl/dz_pkg.sv
package dz_pkg;

  // Condition record, packed so that lt lands in bit 3 and so in bit 0
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } dz_cr_t;

  localparam int CR_BITS = $bits(dz_cr_t);

endpackage

// File: rtl/dz_compare.sv
module dz_compare #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic             lhs_gt_rhs
);

  // Signed magnitude test, kept apart from the subtractor
  always_comb begin
    lhs_gt_rhs = $signed(lhs) > $signed(rhs);
  end

endmodule

// File: rtl/dz_subtract.sv
module dz_subtract #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  input  logic             take,
  output logic [WIDTH-1:0] diff,
  output logic             wrapped
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] raw;

  always_comb begin
    raw     = minuend - subtrahend;
    diff    = take ? raw : '0;
    // A performed subtraction is meant to be positive; a set sign bit means it wrapped
    wrapped = take & raw[MSB];
  end

endmodule

// File: rtl/dz_flags.sv
module dz_flags
  import dz_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  input  logic             wrapped,
  input  logic             ov_en,
  input  logic             rec_en,
  input  logic             so_prev,
  input  logic             ov_prev,
  output logic             ov_next,
  output logic             so_next,
  output logic             cr_we,
  output dz_cr_t           cr_next
);

  localparam int MSB = WIDTH - 1;

  logic is_zero;

  // Status bits first: the record copies the updated summary bit
  always_comb begin
    ov_next = ov_en ? wrapped : ov_prev;
    so_next = so_prev | (ov_en & wrapped);
  end

  always_comb begin
    is_zero = (value == '0);
    cr_we   = rec_en;
    cr_next = '0;
    if (rec_en) begin
      cr_next.lt = value[MSB];
      cr_next.gt = ~value[MSB] & ~is_zero;
      cr_next.eq = is_zero;
      cr_next.so = so_next;
    end
  end

endmodule

// File: rtl/dz_unit.sv
module dz_unit
  import dz_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             ov_en,
  input  logic             rec_en,
  input  logic             xer_so_in,
  input  logic             xer_ov_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             xer_ov_out,
  output logic             xer_so_out,
  output logic             cr_wr,
  output logic [3:0]       cr_field
);

  localparam int MSB = WIDTH - 1;

  logic             b_above;
  logic [WIDTH-1:0] diff_c;
  logic             wrap_c;
  logic             ov_c;
  logic             so_c;
  logic             crwe_c;
  dz_cr_t           cr_c;

  dz_compare #(.WIDTH(WIDTH)) u_cmp (
    .lhs        (op_b),
    .rhs        (op_a),
    .lhs_gt_rhs (b_above)
  );

  dz_subtract #(.WIDTH(WIDTH)) u_sub (
    .minuend    (op_b),
    .subtrahend (op_a),
    .take       (b_above),
    .diff       (diff_c),
    .wrapped    (wrap_c)
  );

  dz_flags #(.WIDTH(WIDTH)) u_flg (
    .value   (diff_c),
    .wrapped (wrap_c),
    .ov_en   (ov_en),
    .rec_en  (rec_en),
    .so_prev (xer_so_in),
    .ov_prev (xer_ov_in),
    .ov_next (ov_c),
    .so_next (so_c),
    .cr_we   (crwe_c),
    .cr_next (cr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      xer_ov_out <= 1'b0;
      xer_so_out <= 1'b0;
      cr_wr      <= 1'b0;
      cr_field   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= diff_c;
        xer_ov_out <= ov_c;
        xer_so_out <= so_c;
        cr_wr      <= crwe_c;
        cr_field   <= cr_c;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid)); // R1
  AST_ZERO_WHEN_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !($signed($past(op_b)) > $signed($past(op_a)))) |-> (result == '0)); // R3
  AST_DIFF_WHEN_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($signed($past(op_b)) > $signed($past(op_a)))) |-> (result == $past(op_b) - $past(op_a))); // R2
  AST_OV_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(ov_en)) |-> (xer_ov_out == result[MSB])); // R4
  AST_OV_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(ov_en)) |-> (xer_ov_out == $past(xer_ov_in))); // R5
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(xer_so_in)) |-> xer_so_out); // R6
  AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cr_wr) |-> (cr_field[0] == xer_so_out)); // R7
  AST_CR_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cr_wr) |-> ($countones(cr_field[3:1]) == 1)); // R7
  AST_NO_RECORD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rec_en)) |-> (!cr_wr && cr_field == 4'b0000)); // R8

endmodule

// File: tb/tb_dz_unit.sv
module tb_dz_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          ov_en = 1'b0;
  logic          rec_en = 1'b0;
  logic          so_in = 1'b0;
  logic          ov_in = 1'b0;
  logic          out_valid;
  logic [W-1:0]  result;
  logic          ov_out;
  logic          so_out;
  logic          cr_wr;
  logic [3:0]    cr_field;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic [W-1:0] e_res = '0;
  logic         e_ov = 1'b0, e_so = 1'b0, e_crw = 1'b0, e_val = 1'b0;
  logic [3:0]   e_cr = '0;
  logic         e_above = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dz_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .ov_en(ov_en), .rec_en(rec_en), .xer_so_in(so_in), .xer_ov_in(ov_in),
    .out_valid(out_valid), .result(result), .xer_ov_out(ov_out),
    .xer_so_out(so_out), .cr_wr(cr_wr), .cr_field(cr_field)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R1 valid", {31'b0, out_valid}, {31'b0, e_val});
    check(e_above ? "R2 result" : "R3 result", result, e_res);
    check(ov_en_prev ? "R4 ov" : "R5 ov", {31'b0, ov_out}, {31'b0, e_ov});
    check("R6 so", {31'b0, so_out}, {31'b0, e_so});
    check(e_crw ? "R7 cr_wr" : "R8 cr_wr", {31'b0, cr_wr}, {31'b0, e_crw});
    check(e_crw ? "R7 cr_field" : "R8 cr_field", {28'b0, cr_field}, {28'b0, e_cr});
  endtask

  logic ov_en_prev = 1'b0;

  // Drive at a falling edge, predict, then compare at the next falling edge
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic oe, input logic re, input logic si, input logic oi);
    longint sa, sb, d;
    logic [W-1:0] r;
    logic wrap;
    in_valid = v; op_a = a; op_b = b; ov_en = oe; rec_en = re; so_in = si; ov_in = oi;
    e_val = v;
    if (v) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      e_above = sb > sa;
      if (e_above) begin
        d = sb - sa;
        r = d[W-1:0];
      end else begin
        r = '0;
      end
      wrap = e_above && (d > longint'(32'h7fffffff));
      e_res = r;
      e_ov  = oe ? wrap : oi;
      e_so  = si | (oe & wrap);
      e_crw = re;
      e_cr  = re ? {r[W-1], (!r[W-1] && r != 0), (r == 0), e_so} : 4'b0000;
      ov_en_prev = oe;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    compare_all();
    // R2 plain positive difference, with record
    step(1, 32'd5, 32'd12, 1, 1, 0, 1);
    // R3 equal operands -> zero, EQ set; R4 ov cleared under ov_en
    step(1, 32'd77, 32'd77, 1, 1, 0, 1);
    // R3 a greater -> zero
    step(1, 32'd9, 32'd3, 0, 1, 0, 1);
    // R3 signed: a positive, b negative -> zero
    step(1, 32'd1, 32'hffff_ffff, 1, 0, 1, 0);
    // R2 signed: a negative, b positive
    step(1, 32'hffff_fff0, 32'd16, 1, 1, 0, 0);
    // R4 R6 overflow: a = most negative, b = most positive
    step(1, 32'h8000_0000, 32'h7fff_ffff, 1, 1, 0, 0);
    // R5 overflow case with ov_en clear: ov passes, so unchanged
    step(1, 32'h8000_0000, 32'h0000_0001, 0, 1, 0, 0);
    // R6 sticky so, no overflow
    step(1, 32'd0, 32'd1, 1, 1, 1, 1);
    // R1 hold while idle
    step(0, 32'h1234_5678, 32'hffff_0000, 1, 0, 0, 1);
    step(0, 32'h0, 32'h7fff_ffff, 1, 1, 1, 1);
    // R8 no record
    step(1, 32'h8000_0000, 32'h7fff_ffff, 1, 0, 0, 0);
    // R2 off-by-one boundary
    step(1, 32'h7fff_fffe, 32'h7fff_ffff, 0, 1, 1, 0);
    // Mixed sweep
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 4 == 0) ra = {1'b1, ra[W-2:0]};
      if (i % 4 == 0) rb = {1'b0, rb[W-2:0]};
      step(($urandom() % 5) != 0, ra, rb, $urandom() % 2, $urandom() % 2,
           $urandom() % 2, $urandom() % 2);
    end
    // R1 synchronous reset clears outputs
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    e_val = 0; e_res = '0; e_ov = 0; e_so = 0; e_crw = 0; e_cr = '0; e_above = 0;
    compare_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule